// File: doc/BRIEF.md
# Dual-Sequencer Interrupt Status and Enable Controller

This block keeps the interrupt state of two command sequencers, a main one and a secondary one. Each sequencer has a 32-bit sticky status register and a 32-bit enable register. Single-cycle event pulses from the datapath set status bits. Software reads the registers through a simple register port. It can also write through aliased addresses: one clears status bits, one sets enable bits and one clears enable bits. Each alias acts only on the bits written as 1. A direct write to the enable register replaces the whole mask.

Each sequencer drives one interrupt line. The line is a flop that holds the OR of all status bits that are also enabled. The main status register carries a summary bit in position 31. That bit reads as 1 while any secondary status bit is set, so one read of the main status shows whether the secondary side needs attention. The usual service routine reads a status register and writes the same value back to its clear alias. This removes exactly the events it has seen and leaves events that arrived later in place.

Top module: `dual_seq_irq_ctrl`

## Requirements
- R1: After reset, every status and enable register reads 0, and both interrupt outputs are 0.
- R2: An event pulse on bit i of an event input sets bit i of that sequencer's status register at the next clock edge. The bit stays set until a status-clear write removes it.
- R3: A write to status-clear (base+0x8) clears only the bits written as 1. Writing back a value just read from status clears exactly those bits.
- R4: When an event pulse and a status-clear of the same bit arrive in the same cycle, the event wins and the bit stays set.
- R5: A write to the direct enable register (base+0x4) replaces every enable bit with the written value.
- R6: A write to enable-set (base+0xC) sets only the bits written as 1. A write to enable-clear (base+0x10) clears only the bits written as 1. All other enable bits keep their values.
- R7: Each interrupt output equals, one clock later, the OR of that sequencer's readable status bits ANDed with its enable bits.
- R8: Bit 31 of the main status reads 1 exactly when some secondary status bit is set. Main event bit 31 and a main status-clear of bit 31 do not affect it. Through main enable bit 31, it drives the main interrupt output.
- R9: The main registers sit at base 0x610 and the secondary registers at base 0x640. Read data is combinational from the address. The three write aliases and all unmapped addresses read 0. Writes to a status address or to an unmapped address change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| addr | input | 12 | Byte address of the register access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the register at `addr` (combinational) |
| main_evt | input | 32 | Event pulses for the main sequencer, one bit per cause |
| sec_evt | input | 32 | Event pulses for the secondary sequencer, one bit per cause |
| main_irq | output | 1 | Registered main sequencer interrupt |
| sec_irq | output | 1 | Registered secondary sequencer interrupt |

## Verification
The properties assume synchronous, single-cycle inputs. They assume `addr` and `wr_en` are sampled at the clock edge and that events and writes may arrive in any combination in the same cycle. Under those assumptions, they check that status bits never drop without a clear write, that enables move only on writes to their own addresses, and that the interrupt flops follow status AND enable with one cycle of lag.

The stimulus changes inputs only on the falling edge. It keeps the random event masks sparse, so that bits stay set long enough for clears and enable changes to be seen. It draws addresses mostly from the ten mapped registers, with an occasional unmapped one.

// File: rtl/irqc_pkg.sv
`timescale 1ns/1ps
package irqc_pkg;

    localparam int unsigned DATA_W   = 32;
    localparam int unsigned ADDR_W   = 12;
    localparam int unsigned NUM_SEQ  = 2;
    localparam int unsigned SUM_BIT  = 31;

    // register offsets inside one sequencer window
    localparam int unsigned OFF_STAT   = 'h00;
    localparam int unsigned OFF_EN     = 'h04;
    localparam int unsigned OFF_STCLR  = 'h08;
    localparam int unsigned OFF_ENSET  = 'h0C;
    localparam int unsigned OFF_ENCLR  = 'h10;
    localparam int unsigned WIN_LAST   = OFF_ENCLR;

    localparam logic [ADDR_W-1:0] MAIN_BASE = 12'h610;
    localparam logic [ADDR_W-1:0] SEC_BASE  = 12'h640;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_STAT,
        SEL_EN,
        SEL_STCLR,
        SEL_ENSET,
        SEL_ENCLR
    } reg_sel_e;

    typedef struct packed {
        logic en_load;
        logic en_or;
        logic en_andn;
        logic st_clr;
    } wr_strb_t;

    function automatic reg_sel_e sel_of_offset(input logic [ADDR_W-1:0] off);
        reg_sel_e s;
        case (int'(off))
            OFF_STAT:  s = SEL_STAT;
            OFF_EN:    s = SEL_EN;
            OFF_STCLR: s = SEL_STCLR;
            OFF_ENSET: s = SEL_ENSET;
            OFF_ENCLR: s = SEL_ENCLR;
            default:   s = SEL_NONE;
        endcase
        return s;
    endfunction

    function automatic logic [ADDR_W-1:0] base_of(input int unsigned seq);
        return (seq == 0) ? MAIN_BASE : SEC_BASE;
    endfunction

endpackage

// File: rtl/irqc_decode.sv
`timescale 1ns/1ps
module irqc_decode
    import irqc_pkg::*;
#(
    parameter int unsigned AW = ADDR_W,
    parameter logic [AW-1:0] BASE = '0
) (
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    output reg_sel_e      sel,
    output wr_strb_t      strb
);
    localparam logic [AW-1:0] LAST = AW'(WIN_LAST);

    logic [AW-1:0] off;
    logic          in_win;

    always_comb begin
        off    = addr - BASE;
        in_win = (addr >= BASE) && (off <= LAST) && (off[1:0] == 2'b00);
        sel    = in_win ? sel_of_offset(off) : SEL_NONE;
        strb.en_load = wr_en && (sel == SEL_EN);
        strb.en_or   = wr_en && (sel == SEL_ENSET);
        strb.en_andn = wr_en && (sel == SEL_ENCLR);
        strb.st_clr  = wr_en && (sel == SEL_STCLR);
    end
endmodule

// File: rtl/irqc_bank.sv
`timescale 1ns/1ps
module irqc_bank
    import irqc_pkg::*;
#(
    parameter int unsigned DW      = DATA_W,
    parameter bit          HAS_SUM = 1'b0,
    parameter int unsigned SB      = SUM_BIT
) (
    input  logic          clk,
    input  logic          rst,
    input  wr_strb_t      strb,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] evt,
    input  logic          sum_in,
    output logic [DW-1:0] stat_q,
    output logic [DW-1:0] view,
    output logic [DW-1:0] en_q,
    output logic          irq_q
);
    // bit owned by the summary input rather than by stored state
    localparam logic [DW-1:0] SUM_MASK = HAS_SUM ? (DW'(1) << SB) : '0;

    logic [DW-1:0] stat_d;
    logic [DW-1:0] en_d;
    logic [DW-1:0] clr_bits;

    always_comb begin
        clr_bits = strb.st_clr ? wdata : '0;
        // event is ORed after the clear so it dominates
        stat_d   = ((stat_q & ~clr_bits) | evt) & ~SUM_MASK;
        if (strb.en_load)      en_d = wdata;
        else if (strb.en_or)   en_d = en_q | wdata;
        else if (strb.en_andn) en_d = en_q & ~wdata;
        else                   en_d = en_q;
        view = (stat_q & ~SUM_MASK) | (sum_in ? SUM_MASK : '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
            en_q   <= '0;
            irq_q  <= 1'b0;
        end else begin
            stat_q <= stat_d;
            en_q   <= en_d;
            irq_q  <= |(view & en_q);
        end
    end
endmodule

// File: rtl/irqc_rdmux.sv
`timescale 1ns/1ps
module irqc_rdmux
    import irqc_pkg::*;
#(
    parameter int unsigned DW = DATA_W,
    parameter int unsigned NS = NUM_SEQ
) (
    input  reg_sel_e      sel   [NS],
    input  logic [DW-1:0] view  [NS],
    input  logic [DW-1:0] en    [NS],
    output logic [DW-1:0] rdata
);
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NS; i++) begin
            if (sel[i] == SEL_STAT) rdata = rdata | view[i];
            if (sel[i] == SEL_EN)   rdata = rdata | en[i];
        end
    end
endmodule

// File: rtl/dual_seq_irq_ctrl.sv
`timescale 1ns/1ps
module dual_seq_irq_ctrl
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [DATA_W-1:0] main_evt,
    input  logic [DATA_W-1:0] sec_evt,
    output logic              main_irq,
    output logic              sec_irq
);
    reg_sel_e          sel    [NUM_SEQ];
    wr_strb_t          strb   [NUM_SEQ];
    logic [DATA_W-1:0] evt    [NUM_SEQ];
    logic [DATA_W-1:0] stat_q [NUM_SEQ];
    logic [DATA_W-1:0] view   [NUM_SEQ];
    logic [DATA_W-1:0] en_q   [NUM_SEQ];
    logic              irq    [NUM_SEQ];
    logic              sum    [NUM_SEQ];

    assign evt[0] = main_evt;
    assign evt[1] = sec_evt;
    // main carries the summary of the secondary stored status
    assign sum[0] = |stat_q[1];
    assign sum[1] = 1'b0;

    for (genvar g = 0; g < NUM_SEQ; g++) begin : g_seq
        irqc_decode #(
            .AW   (ADDR_W),
            .BASE (base_of(g))
        ) u_dec (
            .wr_en (wr_en),
            .addr  (addr),
            .sel   (sel[g]),
            .strb  (strb[g])
        );

        irqc_bank #(
            .DW      (DATA_W),
            .HAS_SUM (g == 0),
            .SB      (SUM_BIT)
        ) u_bank (
            .clk    (clk),
            .rst    (rst),
            .strb   (strb[g]),
            .wdata  (wdata),
            .evt    (evt[g]),
            .sum_in (sum[g]),
            .stat_q (stat_q[g]),
            .view   (view[g]),
            .en_q   (en_q[g]),
            .irq_q  (irq[g])
        );
    end

    irqc_rdmux #(
        .DW (DATA_W),
        .NS (NUM_SEQ)
    ) u_rd (
        .sel   (sel),
        .view  (view),
        .en    (en_q),
        .rdata (rdata)
    );

    assign main_irq = irq[0];
    assign sec_irq  = irq[1];
endmodule

// File: rtl/irqc_chk.sv
`timescale 1ns/1ps
module irqc_chk
    import irqc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] rdata,
    input logic [DATA_W-1:0] main_evt,
    input logic [DATA_W-1:0] sec_evt,
    input logic              main_irq,
    input logic              sec_irq,
    input logic [DATA_W-1:0] m_view,
    input logic [DATA_W-1:0] m_en,
    input logic [DATA_W-1:0] s_stat,
    input logic [DATA_W-1:0] s_en
);
    localparam logic [DATA_W-1:0] NOSUM = ~(DATA_W'(1) << SUM_BIT);

    logic m_clr_w, s_clr_w, m_en_w, s_en_w;
    assign m_clr_w = wr_en && (addr == MAIN_BASE + 12'h8);
    assign s_clr_w = wr_en && (addr == SEC_BASE  + 12'h8);
    assign m_en_w  = wr_en && (addr == MAIN_BASE + 12'h4 || addr == MAIN_BASE + 12'hC
                               || addr == MAIN_BASE + 12'h10);
    assign s_en_w  = wr_en && (addr == SEC_BASE + 12'h4 || addr == SEC_BASE + 12'hC
                               || addr == SEC_BASE + 12'h10);

    // R1
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (m_view == '0 && m_en == '0 && s_stat == '0 && s_en == '0
                        && !main_irq && !sec_irq));

    // R2
    a_r2_main_sticky: assert property (@(posedge clk) disable iff (rst)
        !m_clr_w |=> ((($past(m_view) & NOSUM) & ~m_view) == '0));
    a_r2_sec_sticky: assert property (@(posedge clk) disable iff (rst)
        !s_clr_w |=> (($past(s_stat) & ~s_stat) == '0));

    // R4
    a_r4_main_event_wins: assert property (@(posedge clk) disable iff (rst)
        (main_evt != '0) |=> ((m_view & $past(main_evt & NOSUM)) == $past(main_evt & NOSUM)));
    a_r4_sec_event_wins: assert property (@(posedge clk) disable iff (rst)
        (sec_evt != '0) |=> ((s_stat & $past(sec_evt)) == $past(sec_evt)));

    // R6
    a_r6_main_en_hold: assert property (@(posedge clk) disable iff (rst)
        !m_en_w |=> $stable(m_en));
    a_r6_sec_en_hold: assert property (@(posedge clk) disable iff (rst)
        !s_en_w |=> $stable(s_en));

    // R7
    a_r7_main_irq: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (main_irq == $past(|(m_view & m_en))));
    a_r7_sec_irq: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (sec_irq == $past(|(s_stat & s_en))));

    // R8
    a_r8_summary_read: assert property (@(posedge clk) disable iff (rst)
        (addr == MAIN_BASE) |-> (rdata[SUM_BIT] == (|s_stat)));
endmodule

bind dual_seq_irq_ctrl irqc_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .addr     (addr),
    .rdata    (rdata),
    .main_evt (main_evt),
    .sec_evt  (sec_evt),
    .main_irq (main_irq),
    .sec_irq  (sec_irq),
    .m_view   (view[0]),
    .m_en     (en_q[0]),
    .s_stat   (stat_q[1]),
    .s_en     (en_q[1])
);

// File: tb/tb_dual_seq_irq_ctrl.sv
`timescale 1ns/1ps
module tb_dual_seq_irq_ctrl;
    localparam logic [11:0] MB = 12'h610;
    localparam logic [11:0] SB = 12'h640;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [31:0] main_evt = '0;
    logic [31:0] sec_evt = '0;
    logic        main_irq, sec_irq;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    // reference state
    logic [31:0] m_st = '0, m_en = '0, s_st = '0, s_en = '0;
    logic        e_mirq = 1'b0, e_sirq = 1'b0;

    always #4 clk = ~clk;

    dual_seq_irq_ctrl dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .main_evt(main_evt), .sec_evt(sec_evt),
        .main_irq(main_irq), .sec_irq(sec_irq)
    );

    function automatic logic [31:0] m_view();
        return {|s_st, m_st[30:0]};
    endfunction

    function automatic logic [31:0] exp_read(input logic [11:0] a);
        case (a)
            MB:          return m_view();
            MB + 12'h4:  return m_en;
            SB:          return s_st;
            SB + 12'h4:  return s_en;
            default:     return 32'h0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_step(input logic w, input logic [11:0] a, input logic [31:0] d,
                              input logic [31:0] me, input logic [31:0] se);
        e_mirq = |(m_view() & m_en);
        e_sirq = |(s_st & s_en);
        if (w) begin
            case (a)
                MB + 12'h4:  m_en = d;
                MB + 12'h8:  m_st = m_st & ~d;
                MB + 12'hC:  m_en = m_en | d;
                MB + 12'h10: m_en = m_en & ~d;
                SB + 12'h4:  s_en = d;
                SB + 12'h8:  s_st = s_st & ~d;
                SB + 12'hC:  s_en = s_en | d;
                SB + 12'h10: s_en = s_en & ~d;
                default: ;
            endcase
        end
        m_st = (m_st | me) & 32'h7FFF_FFFF;
        s_st = s_st | se;
    endtask

    // one clock: inputs driven now (away from rising edge), model follows the edge
    task automatic tick(input logic w, input logic [11:0] a, input logic [31:0] d,
                        input logic [31:0] me, input logic [31:0] se);
        wr_en = w; addr = a; wdata = d; main_evt = me; sec_evt = se;
        @(posedge clk);
        model_step(w, a, d, me, se);
        @(negedge clk);
        wr_en = 1'b0; main_evt = '0; sec_evt = '0;
    endtask

    task automatic idle();
        tick(1'b0, 12'h000, 32'h0, 32'h0, 32'h0);
    endtask

    task automatic chk_read(input string tag, input logic [11:0] a);
        addr = a;
        #1;
        check(tag, rdata, exp_read(a));
    endtask

    task automatic chk_irq(input string tag);
        check({tag, " main_irq"}, {31'h0, main_irq}, {31'h0, e_mirq});
        check({tag, " sec_irq"},  {31'h0, sec_irq},  {31'h0, e_sirq});
    endtask

    task automatic chk_all(input string tag);
        chk_read({tag, " main stat"}, MB);
        chk_read({tag, " main en"},   MB + 12'h4);
        chk_read({tag, " sec stat"},  SB);
        chk_read({tag, " sec en"},    SB + 12'h4);
        chk_irq(tag);
    endtask

    initial begin
        #(8 * 190000);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'h1234_5678));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk_all("R1 reset");
        check("R1 literal main stat", exp_read(MB), 32'h0);

        // R2 event sets a sticky bit
        tick(1'b0, 12'h0, 32'h0, 32'h0000_0008, 32'h0);
        chk_read("R2 main event bit3", MB);
        check("R2 literal", rdata, 32'h0000_0008);
        repeat (3) idle();
        chk_read("R2 sticky", MB);

        // R7 enable then irq one cycle later
        tick(1'b1, MB + 12'hC, 32'h0000_0008, 32'h0, 32'h0);
        chk_irq("R7 after enable-set edge");
        idle();
        chk_irq("R7 irq rises");
        check("R7 literal", {31'h0, main_irq}, 32'h1);

        // R3 write back read value
        addr = MB; #1; v = rdata;
        tick(1'b0, 12'h0, 32'h0, 32'h0000_0021, 32'h0);
        tick(1'b1, MB + 12'h8, v, 32'h0, 32'h0);
        chk_read("R3 clear seen bits only", MB);
        check("R3 literal", rdata, 32'h0000_0021);
        idle();
        chk_irq("R3 irq drop");

        // R4 event and clear same bit
        tick(1'b1, MB + 12'h8, 32'h0000_0001, 32'h0000_0001, 32'h0);
        chk_read("R4 event wins", MB);
        check("R4 literal", rdata & 32'h1, 32'h1);
        tick(1'b1, SB + 12'h8, 32'h0, 32'h0, 32'h0400_0000);
        tick(1'b1, SB + 12'h8, 32'h0400_0000, 32'h0, 32'h0400_0000);
        chk_read("R4 secondary event wins", SB);

        // R5 direct enable replaces all bits
        tick(1'b1, MB + 12'h4, 32'hA5A5_0F0F, 32'h0, 32'h0);
        chk_read("R5 direct load", MB + 12'h4);
        tick(1'b1, MB + 12'h4, 32'h0000_1000, 32'h0, 32'h0);
        chk_read("R5 replace", MB + 12'h4);
        check("R5 literal", rdata, 32'h0000_1000);

        // R6 set and clear touch only ones
        tick(1'b1, SB + 12'h4, 32'h00F0_00F0, 32'h0, 32'h0);
        tick(1'b1, SB + 12'hC, 32'h0000_0F00, 32'h0, 32'h0);
        chk_read("R6 set", SB + 12'h4);
        tick(1'b1, SB + 12'h10, 32'h00F0_0010, 32'h0, 32'h0);
        chk_read("R6 clear", SB + 12'h4);
        check("R6 literal", rdata, 32'h0000_0FE0);

        // R8 summary bit
        tick(1'b1, SB + 12'h8, 32'hFFFF_FFFF, 32'h8000_0000, 32'h0);
        chk_read("R8 summary low, main evt31 ignored", MB);
        check("R8 literal low", rdata & 32'h8000_0000, 32'h0);
        tick(1'b1, MB + 12'h4, 32'h8000_0000, 32'h0, 32'h0002_0000);
        chk_read("R8 summary high", MB);
        tick(1'b1, MB + 12'h8, 32'h8000_0000, 32'h0, 32'h0);
        chk_read("R8 main clear ignores summary", MB);
        check("R8 literal high", rdata & 32'h8000_0000, 32'h8000_0000);
        idle();
        chk_irq("R8 summary drives main irq");

        // R9 aliases read zero, writes to status/unmapped ignored
        chk_read("R9 alias stclr", MB + 12'h8);
        chk_read("R9 alias enset", SB + 12'hC);
        chk_read("R9 alias enclr", SB + 12'h10);
        tick(1'b1, MB, 32'hFFFF_FFFF, 32'h0, 32'h0);
        tick(1'b1, 12'h630, 32'hFFFF_FFFF, 32'h0, 32'h0);
        tick(1'b1, MB + 12'h6, 32'hFFFF_FFFF, 32'h0, 32'h0);
        tick(1'b1, SB + 12'h14, 32'hFFFF_FFFF, 32'h0, 32'h0);
        chk_all("R9 ignored writes");
        check("R9 literal unmapped read", exp_read(12'h630), 32'h0);
        chk_read("R9 unmapped read", 12'h630);

        // random mix
        for (int n = 0; n < 3000; n++) begin
            int unsigned pick;
            logic [11:0] a;
            logic [31:0] d, me, se;
            pick = $urandom % 11;
            if (pick == 10) a = 12'h600 + 12'($urandom % 12'h80);
            else            a = ((pick < 5) ? MB : SB) + 12'((pick % 5) * 4);
            d  = (($urandom % 4) == 0) ? exp_read(a & 12'hFF0) : $urandom;
            me = $urandom & $urandom & $urandom & $urandom;
            se = $urandom & $urandom & $urandom & $urandom;
            if (($urandom % 3) == 0) begin me = '0; se = '0; end
            tick(($urandom % 4) != 0, a, d, me, se);
            chk_irq("R7 random");
            chk_read("R2 R3 R6 random read", ($urandom % 2) ? MB + 12'(($urandom % 2) * 4)
                                                           : SB + 12'(($urandom % 2) * 4));
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule